// File: doc/BRIEF.md
# Mirrored-Counter PWM Modulator

This block turns an N-bit duty word into a one-bit pulse stream for an external RC lowpass filter, which makes a low-cost DAC. A free-running N-bit counter steps once for each clock in which the step input is high, so a slower pulse rate can be had by feeding that input from a divider. A full frame lasts 2^N stepped clocks. The output goes high whenever the frame's duty word is strictly larger than the value it is compared against.

In the default mode that value is the counter with its bit order reversed: counter bit i feeds comparator position N-1-i. The number of high clocks per frame stays the same, but the high clocks are spread through the frame instead of forming one block. This raises the ripple frequency the filter has to remove. A mode input selects the plain counter instead, so the two waveforms can be compared on the bench or on the board. The mirror is wiring only, and the mode multiplexer is the one piece of logic it adds.

The duty word and the mode are captured together at the frame boundary, so a frame never mixes two settings. The output is a register that only updates on stepped clocks.

Top module: `brpwm_dac`

## Requirements
- R1: The frame counter advances by one on each clock with `step_i` high and holds on each clock with `step_i` low; while it holds, `pwm_o` also holds its value.
- R2: A frame is 2^N stepped clocks long, and the output pattern repeats with that period as long as the duty word and the mode do not change.
- R3: With `mirror_i` = 0 (plain mode), the value of `pwm_o` after the stepped clock taken at counter value c is 1 exactly when the frame duty D > c.
- R4: With `mirror_i` = 1 (mirrored mode), the value of `pwm_o` after the stepped clock taken at counter value c is 1 exactly when D > rev(c), where rev(c) puts bit i of c at position N-1-i.
- R5: In both modes, each frame holds exactly D high stepped clocks.
- R6: In mirrored mode at half scale (D = 2^(N-1)), the output toggles on every stepped clock and is high at even counter values.
- R7: At D = 1, both modes give the same frame: a single high clock, at counter value 0.
- R8: D = 0 gives a frame that is low throughout. D = 2^N-1 gives a frame with exactly one low clock.
- R9: `duty_i` and `mirror_i` are captured only on the stepped clock at which the counter is at 2^N-1. Changes at any other time have no effect on the frame in progress.
- R10: `pwm_o` is registered: it changes only on a rising clock edge with `step_i` high, and it reflects the comparison made at that edge.
- R11: While `rst_i` is high at a rising edge, the counter, the captured duty and `pwm_o` clear to zero. The first frame after reset is therefore all low, whatever `duty_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Counter advance enable (prescaler tick) |
| mirror_i | input | 1 | 1 = bit-reversed compare, 0 = plain compare |
| duty_i | input | DUTY_W | Duty word, captured at the frame boundary |
| pwm_o | output | 1 | Registered pulse output |

## Verification
The bench uses a 4-bit build and sweeps every duty word in both modes. It predicts each output bit from the compare rule and counts the high clocks in each frame. The sweep tells the plain and mirrored orderings apart bit by bit, while the high count confirms that the average stays the same. Half scale, a duty of one, zero and full scale get their own checks.

Some frames have idle clocks inserted, which separates true counter holding from free running. Other frames have the duty word and the mode scrambled in the middle, which shows whether capture happens only at the frame boundary. A reset with a nonzero duty word present confirms that the first frame is empty.

// File: rtl/brpwm_pkg.sv
package brpwm_pkg;

   typedef enum logic {
      CMP_PLAIN  = 1'b0,
      CMP_MIRROR = 1'b1
   } cmp_mode_e;

   localparam int unsigned MIN_DUTY_W = 2;
   localparam int unsigned MAX_DUTY_W = 24;

endpackage

// File: rtl/brpwm_counter.sv
module brpwm_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         step_i,
   output logic [W-1:0] cnt_o,
   output logic         last_o
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == TOP);

   // R1: counter holds when not stepped
   a_r1_hold : assert property (@(posedge clk_i) disable iff (rst_i)
      !step_i |=> $stable(cnt_q));

   // R1: counter advances by one when stepped
   a_r1_step : assert property (@(posedge clk_i) disable iff (rst_i)
      step_i |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R2: frame closes back at zero
   a_r2_wrap : assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && last_o) |=> (cnt_q == '0));

endmodule

// File: rtl/brpwm_mirror.sv
module brpwm_mirror #(
   parameter int unsigned W          = 8,
   parameter bit          HAS_MIRROR = 1'b1
) (
   input  logic                      mode_i,
   input  logic [W-1:0]              cnt_i,
   output logic [W-1:0]              cmp_o
);

   import brpwm_pkg::*;

   if (HAS_MIRROR) begin : g_mirror
      logic [W-1:0] rev;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign rev[i] = cnt_i[W-1-i];
      end
      assign cmp_o = (cmp_mode_e'(mode_i) == CMP_MIRROR) ? rev : cnt_i;
   end else begin : g_plain
      logic unused_mode;
      assign unused_mode = mode_i;
      assign cmp_o       = cnt_i;
   end

endmodule

// File: rtl/brpwm_shadow.sv
module brpwm_shadow #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         load_i,
   input  logic [W-1:0] duty_i,
   input  logic         mode_i,
   output logic [W-1:0] duty_o,
   output logic         mode_o
);

   import brpwm_pkg::*;

   logic [W-1:0] duty_q;
   cmp_mode_e    mode_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         duty_q <= '0;
         mode_q <= CMP_PLAIN;
      end else if (load_i) begin
         duty_q <= duty_i;
         mode_q <= cmp_mode_e'(mode_i);
      end
   end

   assign duty_o = duty_q;
   assign mode_o = mode_q;

   // R9: captured settings change only at a frame boundary
   a_r9_shadow_hold : assert property (@(posedge clk_i) disable iff (rst_i)
      !load_i |=> ($stable(duty_q) && $stable(mode_q)));

endmodule

// File: rtl/brpwm_dac.sv
module brpwm_dac #(
   parameter int unsigned DUTY_W     = 8,
   parameter bit          HAS_MIRROR = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              step_i,
   input  logic              mirror_i,
   input  logic [DUTY_W-1:0] duty_i,
   output logic              pwm_o
);

   import brpwm_pkg::*;

   localparam int unsigned HW = DUTY_W + 1;

   if (DUTY_W < MIN_DUTY_W || DUTY_W > MAX_DUTY_W) begin : g_bad_width
      $error("brpwm_dac: DUTY_W out of supported range");
   end

   logic [DUTY_W-1:0] cnt;
   logic              last;
   logic              frame_load;
   logic [DUTY_W-1:0] duty_sh;
   logic              mode_sh;
   logic [DUTY_W-1:0] cmp_val;
   logic              hit;
   logic              pwm_q;

   brpwm_counter #(.W(DUTY_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .step_i (step_i),
      .cnt_o  (cnt),
      .last_o (last)
   );

   assign frame_load = step_i & last;

   brpwm_shadow #(.W(DUTY_W)) u_shadow (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (frame_load),
      .duty_i (duty_i),
      .mode_i (mirror_i),
      .duty_o (duty_sh),
      .mode_o (mode_sh)
   );

   brpwm_mirror #(.W(DUTY_W), .HAS_MIRROR(HAS_MIRROR)) u_mirror (
      .mode_i (mode_sh),
      .cnt_i  (cnt),
      .cmp_o  (cmp_val)
   );

   assign hit = (duty_sh > cmp_val);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pwm_q <= 1'b0;
      end else if (step_i) begin
         pwm_q <= hit;
      end
   end

   assign pwm_o = pwm_q;

   // High-clock tally per frame, used only by the R5 check
   logic [HW-1:0] hi_tally;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hi_tally <= '0;
      end else if (step_i) begin
         if (last) begin
            a_r5_duty_count : assert ((hi_tally + HW'(hit)) == HW'(duty_sh))
               else $error("frame high count differs from duty");
            hi_tally <= '0;
         end else begin
            hi_tally <= hi_tally + HW'(hit);
         end
      end
   end

   // R10: output holds between stepped clocks
   a_r10_out_hold : assert property (@(posedge clk_i) disable iff (rst_i)
      !step_i |=> $stable(pwm_q));

   // R8: a zero duty never drives the output high
   a_r8_zero_low : assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && duty_sh == '0) |=> !pwm_q);

   // R11: reset clears the output and the counter
   a_r11_reset_clear : assert property (@(posedge clk_i)
      rst_i |=> (!pwm_q && cnt == '0 && duty_sh == '0));

endmodule

// File: tb/brpwm_dac_tb.sv
module brpwm_dac_tb;

   localparam int W = 4;
   localparam int P = 1 << W;

   logic         clk = 1'b0;
   logic         rst;
   logic         step;
   logic         mirror;
   logic [W-1:0] duty;
   logic         pwm;

   int n_vec  = 0;
   int n_fail = 0;
   int k      = 0;
   int act_d  = 0;
   int act_m  = 0;
   logic last_out = 1'b0;
   logic [P-1:0] frame_bits;

   always #2 clk = ~clk;

   brpwm_dac #(.DUTY_W(W), .HAS_MIRROR(1'b1)) u_dut (
      .clk_i    (clk),
      .rst_i    (rst),
      .step_i   (step),
      .mirror_i (mirror),
      .duty_i   (duty),
      .pwm_o    (pwm)
   );

   function automatic int rev(input int v);
      int r = 0;
      for (int i = 0; i < W; i++) if (v[i]) r |= 1 << (W - 1 - i);
      return r;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (k=%0d d=%0d m=%0d)",
                  req, act, exp, k, act_d, act_m);
      end
   endtask

   // One clock; e selects stepped or idle
   task automatic tick(input logic e);
      logic exp;
      int   c;
      c   = act_m ? rev(k) : k;
      exp = e ? (act_d > c) : last_out;
      step = e;
      @(posedge clk);
      @(negedge clk);
      if (e) begin
         check(act_m ? "R4" : "R3", pwm, exp);
         frame_bits[k] = pwm;
         if (k == P - 1) begin
            act_d = duty;
            act_m = mirror;
         end
         k = (k + 1) % P;
      end else begin
         check("R10/R1 hold", pwm, last_out);
      end
      last_out = pwm;
      step = 1'b0;
   endtask

   // Run a whole frame from k=0; d_next/m_next are captured at its end
   task automatic frame(input int d_next, input int m_next,
                        input bit gaps, input bit scramble);
      int d0, m0, highs;
      d0 = act_d;
      m0 = act_m;
      highs = 0;
      for (int i = 0; i < P; i++) begin
         if (scramble && i > 0 && i < P - 1) begin
            duty   = W'(~d_next);
            mirror = ~1'(m_next);
         end else begin
            duty   = W'(d_next);
            mirror = 1'(m_next);
         end
         tick(1'b1);
         highs += int'(frame_bits[i]);
         if (gaps && (i % 3 == 1)) tick(1'b0);
      end
      check("R5", highs, d0);
      if (d0 == P / 2 && m0 == 1)
         for (int i = 0; i < P; i++) check("R6", frame_bits[i], (i % 2 == 0));
      if (d0 == 1)
         check("R7", frame_bits, 1);
      if (d0 == 0)
         check("R8 zero", frame_bits, 0);
      if (d0 == P - 1)
         check("R8 full", highs, P - 1);
      if (scramble)
         check("R9", highs, d0);
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   initial begin
      rst = 1'b1; step = 1'b1; mirror = 1'b1; duty = W'(9);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 out", pwm, 0);
      rst = 1'b0;
      step = 1'b0;
      k = 0; act_d = 0; act_m = 0; last_out = 1'b0;
      // First frame after reset must be empty despite duty_i=9 (R11)
      frame(0, 0, 1'b0, 1'b0);
      check("R11 first frame", frame_bits, 0);
      for (int m = 0; m < 2; m++)
         for (int d = 0; d < P; d++)
            frame(d, m, (d % 4 == 3), (d % 2 == 1));
      // Same setting twice in a row: R2 frame repetition
      frame(5, 1, 1'b0, 1'b0);
      frame(5, 1, 1'b0, 1'b0);
      begin
         logic [P-1:0] prev;
         prev = frame_bits;
         frame(0, 0, 1'b1, 1'b0);
         check("R2", frame_bits, prev);
      end
      frame(0, 0, 1'b0, 1'b0);
      finish_up();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

endmodule